// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port

This block is one parallel I/O port of a small 8-bit microcontroller. Each pin has an output latch that the core writes over its internal bus, either as a whole byte or one bit at a time. The core can read the port back along two paths. One returns the latch contents and is used by read-modify-write operations. The other returns the pin level after a two-stage synchronizer.

The pad is modelled as separate control lines: a drive-low enable, a strong drive-high enable, a weak pull-up enable and an overall output enable. This lets a testbench resolve the real pin level. While an external memory bus cycle is in progress, the drivers take their data from the multiplexed address/data lines instead of the latch. During that time the strong high driver helps a logic one, and any core write to the latch is dropped.

A parameter selects one of two pad variants. In the open-drain variant a logic one is left undriven outside bus cycles. In the pulled-up variant a weak internal pull-up holds a logic one.

Top module: `mcu_io_port`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every latch bit reads 1 and no pin drives low.
- R2: A byte write with the bus idle loads `wr_byte_data` into the latch at the next rising clock edge.
- R3: A bit write with the bus idle sets latch bit `wr_bit_idx` to `wr_bit_val` at the next edge. Every other bit is left unchanged.
- R4: When a byte write and a bit write fall in the same cycle, the indexed bit takes `wr_bit_val` and all other bits take the byte data.
- R5: While `bus_active` is 1, byte and bit writes are dropped and the latch keeps its value.
- R6: With `rd_latch_en` = 1, `rd_data` shows the latch in the same cycle. In a write cycle this is the value from before the write.
- R7: With `rd_pin_en` = 1 and `rd_latch_en` = 0, `rd_data` shows `pin_in` as it was two rising edges earlier. If both strobes are 1, the latch wins. If neither strobe is 1, `rd_data` is 0.
- R8: With the bus idle, a latch bit of 0 sets `drv_low` and `out_en` for that pin. A latch bit of 1 clears `drv_low`, `drv_strong_hi` and `out_en`. `drv_low` is never on together with `drv_strong_hi` or `pull_weak`.
- R9: With `bus_active` = 1, pin i follows `bus_addr_data[i]`. A 1 sets `drv_strong_hi` and `out_en`, and a 0 sets `drv_low` and `out_en`. `drv_strong_hi` is 0 whenever the bus is idle.
- R10: `pull_weak[i]` equals the driven data bit in the pulled-up variant (`PAD_MODE` = PAD_PULLED_UP) and is always 0 in the open-drain variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_byte_en | input | 1 | Full-byte latch write strobe |
| wr_byte_data | input | W | Byte write data |
| wr_bit_en | input | 1 | Single-bit latch write strobe |
| wr_bit_idx | input | IW | Index of the bit to write |
| wr_bit_val | input | 1 | Value for the indexed bit |
| rd_latch_en | input | 1 | Read strobe for the latch path |
| rd_pin_en | input | 1 | Read strobe for the pin path |
| rd_data | output | W | Read data to the internal bus |
| bus_active | input | 1 | External memory bus cycle in progress |
| bus_addr_data | input | W | Multiplexed address/data bits for the pins |
| pin_in | input | W | Pin level from the pad |
| drv_low | output | W | Drive-low enable per pin |
| drv_strong_hi | output | W | Strong drive-high enable per pin |
| pull_weak | output | W | Weak pull-up enable per pin |
| out_en | output | W | Output enable per pin (actively driven) |

## Verification
Three pairs of operations can land in one cycle, and each collision is provoked on purpose. In the first, a latch read falls in the same cycle as a byte write. The bench samples `rd_data` just after driving the write and expects the old latch value, then expects the new value one edge later. In the second, a byte write and a bit write are issued together for every bit index, and the bench compares the result with a byte mask it computes itself. In the third, writes are driven during every cycle of a 256-value bus sweep. The bench checks the driver outputs against the bus data in each cycle, then reads back an unchanged latch once the bus goes idle.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  typedef enum logic {
    PAD_OPEN_DRAIN = 1'b0,
    PAD_PULLED_UP  = 1'b1
  } pad_mode_e;

  typedef struct packed {
    logic low;
    logic strong_hi;
    logic weak_pu;
    logic oe;
  } pad_ctl_t;
endpackage

// File: rtl/io_port_latch.sv
module io_port_latch #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_active,
  input  logic          wr_byte_en,
  input  logic [W-1:0]  wr_byte_data,
  input  logic          wr_bit_en,
  input  logic [IW-1:0] wr_bit_idx,
  input  logic          wr_bit_val,
  output logic [W-1:0]  latch_q
);
  logic [W-1:0] next_q;
  logic         wr_any;

  assign wr_any = (wr_byte_en || wr_bit_en) && !bus_active;

  always_comb begin
    next_q = latch_q;
    if (wr_byte_en) next_q = wr_byte_data;
    if (wr_bit_en && (int'(wr_bit_idx) < W)) next_q[wr_bit_idx] = wr_bit_val;
  end

  always_ff @(posedge clk) begin
    if (rst)         latch_q <= '1;
    else if (wr_any) latch_q <= next_q;
  end

  // R1: the latch comes out of reset all ones
  assert_reset_ones_R1: assert property (@(posedge clk) rst |=> latch_q == '1);

  // R5: a bus cycle freezes the latch
  assert_bus_blocks_write_R5: assert property (@(posedge clk) disable iff (rst)
    bus_active |=> $stable(latch_q));

  // R3: a lone bit write alters at most one bit
  assert_bit_write_scope_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_bit_en && !wr_byte_en) |=> $countones(latch_q ^ $past(latch_q)) <= 1);
endmodule

// File: rtl/io_port_sync.sv
module io_port_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= pin_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];

  // R7: first stage captures the pin one edge later
  assert_sync_first_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stage_q[0] == $past(pin_in));

  // R7: synchronized output advances one stage per edge
  assert_sync_last_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pin_sync == $past(stage_q[STAGES-2]));
endmodule

// File: rtl/io_port_driver.sv
module io_port_driver
  import io_port_pkg::*;
#(
  parameter int        W        = 8,
  parameter pad_mode_e PAD_MODE = PAD_OPEN_DRAIN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_active,
  input  logic [W-1:0] bus_addr_data,
  input  logic [W-1:0] latch_q,
  output logic [W-1:0] drv_low,
  output logic [W-1:0] drv_strong_hi,
  output logic [W-1:0] pull_weak,
  output logic [W-1:0] out_en
);
  localparam logic HAS_PULL = (PAD_MODE == PAD_PULLED_UP);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic     src;
    pad_ctl_t ctl;
    assign src           = bus_active ? bus_addr_data[i] : latch_q[i];
    assign ctl.low       = !src;
    assign ctl.strong_hi = bus_active && src;
    assign ctl.weak_pu   = HAS_PULL && src;
    assign ctl.oe        = ctl.low || ctl.strong_hi;
    assign drv_low[i]       = ctl.low;
    assign drv_strong_hi[i] = ctl.strong_hi;
    assign pull_weak[i]     = ctl.weak_pu;
    assign out_en[i]        = ctl.oe;
  end

  // R8: pull-down never fights a pull-up source
  assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
    (drv_low & (drv_strong_hi | pull_weak)) == '0);

  // R9: strong high only during a bus cycle
  assert_strong_only_bus_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_active |-> drv_strong_hi == '0);

  // R9: during a bus cycle the pins mirror the bus lines
  assert_bus_follow_R9: assert property (@(posedge clk) disable iff (rst)
    bus_active |-> (drv_strong_hi == bus_addr_data) && (out_en == '1));

  // R8: an idle pin holding one is released
  assert_idle_release_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_active |-> out_en == ~latch_q);

  if (!HAS_PULL) begin : g_od_chk
    // R10: open-drain variant has no weak pull-up
    assert_od_no_pull_R10: assert property (@(posedge clk) disable iff (rst)
      pull_weak == '0);
  end
endmodule

// File: rtl/mcu_io_port.sv
module mcu_io_port
  import io_port_pkg::*;
#(
  parameter int        W           = 8,
  parameter int        SYNC_STAGES = 2,
  parameter pad_mode_e PAD_MODE    = PAD_OPEN_DRAIN,
  localparam int       IW          = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_byte_en,
  input  logic [W-1:0]  wr_byte_data,
  input  logic          wr_bit_en,
  input  logic [IW-1:0] wr_bit_idx,
  input  logic          wr_bit_val,
  input  logic          rd_latch_en,
  input  logic          rd_pin_en,
  output logic [W-1:0]  rd_data,
  input  logic          bus_active,
  input  logic [W-1:0]  bus_addr_data,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  drv_low,
  output logic [W-1:0]  drv_strong_hi,
  output logic [W-1:0]  pull_weak,
  output logic [W-1:0]  out_en
);
  logic [W-1:0] latch_q;
  logic [W-1:0] pin_sync;

  io_port_latch #(.W(W), .IW(IW)) u_latch (
    .clk(clk), .rst(rst), .bus_active(bus_active),
    .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
    .wr_bit_en(wr_bit_en), .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val),
    .latch_q(latch_q)
  );

  io_port_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  io_port_driver #(.W(W), .PAD_MODE(PAD_MODE)) u_drv (
    .clk(clk), .rst(rst), .bus_active(bus_active),
    .bus_addr_data(bus_addr_data), .latch_q(latch_q),
    .drv_low(drv_low), .drv_strong_hi(drv_strong_hi),
    .pull_weak(pull_weak), .out_en(out_en)
  );

  always_comb begin
    if (rd_latch_en)    rd_data = latch_q;
    else if (rd_pin_en) rd_data = pin_sync;
    else                rd_data = '0;
  end

  // R6: latch strobe returns the current latch contents
  assert_rd_latch_R6: assert property (@(posedge clk) disable iff (rst)
    rd_latch_en |-> rd_data == latch_q);

  // R7: no strobe, quiet bus
  assert_rd_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!rd_latch_en && !rd_pin_en) |-> rd_data == '0);
endmodule

// File: tb/tb_mcu_io_port.sv
module tb_mcu_io_port;
  import io_port_pkg::*;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, wr_byte_en, wr_bit_en, wr_bit_val, rd_latch_en, rd_pin_en, bus_active;
  logic [W-1:0] wr_byte_data, bus_addr_data, pin_in;
  logic [2:0]   wr_bit_idx;
  logic [W-1:0] rd_pu, low_pu, hi_pu, pull_pu, oe_pu;
  logic [W-1:0] rd_od, low_od, hi_od, pull_od, oe_od;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mcu_io_port #(.W(W), .PAD_MODE(PAD_PULLED_UP)) dut (
    .clk(clk), .rst(rst), .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
    .wr_bit_en(wr_bit_en), .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val),
    .rd_latch_en(rd_latch_en), .rd_pin_en(rd_pin_en), .rd_data(rd_pu),
    .bus_active(bus_active), .bus_addr_data(bus_addr_data), .pin_in(pin_in),
    .drv_low(low_pu), .drv_strong_hi(hi_pu), .pull_weak(pull_pu), .out_en(oe_pu));

  mcu_io_port #(.W(W), .PAD_MODE(PAD_OPEN_DRAIN)) dut_od (
    .clk(clk), .rst(rst), .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
    .wr_bit_en(wr_bit_en), .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val),
    .rd_latch_en(rd_latch_en), .rd_pin_en(rd_pin_en), .rd_data(rd_od),
    .bus_active(bus_active), .bus_addr_data(bus_addr_data), .pin_in(pin_in),
    .drv_low(low_od), .drv_strong_hi(hi_od), .pull_weak(pull_od), .out_en(oe_od));

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr_byte_en = 0; wr_bit_en = 0; wr_bit_val = 0; wr_bit_idx = '0;
    wr_byte_data = '0;
  endtask

  // Expected pad controls for latch L, bus flag b, bus data d (R8, R9, R10)
  task automatic chk_pads(string req, logic [W-1:0] l, logic b, logic [W-1:0] d);
    logic [W-1:0] src;
    src = b ? d : l;
    chk({req, " drv_low"},   low_pu,  ~src);
    chk({req, " strong_hi"}, hi_pu,   b ? src : '0);
    chk({req, " out_en"},    oe_pu,   b ? '1 : ~src);
    chk("R10 pull pulled-up",  pull_pu, src);
    chk("R10 pull open-drain", pull_od, '0);
    chk({req, " od drv_low"}, low_od, ~src);
  endtask

  task automatic load(logic [W-1:0] v);
    wr_byte_en = 1; wr_byte_data = v;
    tick();
    idle_inputs();
  endtask

  initial begin
    rst = 1; idle_inputs(); rd_latch_en = 1; rd_pin_en = 0;
    bus_active = 0; bus_addr_data = '0; pin_in = '0;
    repeat (3) tick();
    chk("R1 reset latch", rd_pu, '1);
    chk("R1 reset latch od", rd_od, '1);
    chk_pads("R1 reset", '1, 0, '0);
    rst = 0;
    tick();
    chk("R1 after reset", rd_pu, '1);

    // R2/R6: every byte value, with read in the write cycle
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] old;
      old = rd_pu;
      wr_byte_en = 1; wr_byte_data = W'(v);
      #1 chk("R6 old value in write cycle", rd_pu, old);
      tick();
      idle_inputs();
      chk("R2 byte write", rd_pu, W'(v));
      chk_pads("R8 idle", W'(v), 0, '0);
    end

    // R3: every bit index and value over several backgrounds
    for (int p = 0; p < 3; p++) begin
      logic [W-1:0] base;
      base = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'hA5;
      for (int i = 0; i < W; i++) begin
        for (int b = 0; b < 2; b++) begin
          logic [W-1:0] exp;
          load(base);
          exp = base;
          exp[i] = b[0];
          wr_bit_en = 1; wr_bit_idx = 3'(i); wr_bit_val = b[0];
          tick();
          idle_inputs();
          chk("R3 bit write", rd_pu, exp);
        end
      end
    end

    // R4: byte and bit writes in the same cycle
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] bytev, exp;
      bytev = 8'h3C ^ W'(i * 17);
      exp = bytev;
      exp[i] = ~bytev[i];
      load(8'h00);
      wr_byte_en = 1; wr_byte_data = bytev;
      wr_bit_en = 1; wr_bit_idx = 3'(i); wr_bit_val = ~bytev[i];
      tick();
      idle_inputs();
      chk("R4 byte+bit collision", rd_pu, exp);
    end

    // R5/R9: bus sweep with writes attempted every cycle
    load(8'h5A);
    bus_active = 1;
    for (int d = 0; d < 256; d++) begin
      bus_addr_data = W'(d);
      wr_byte_en = 1; wr_byte_data = ~W'(d);
      wr_bit_en = 1; wr_bit_idx = 3'(d); wr_bit_val = ~d[0];
      #1 chk_pads("R9 bus drive", 8'h5A, 1, W'(d));
      tick();
      chk("R5 latch held during bus", rd_pu, 8'h5A);
    end
    bus_active = 0; idle_inputs();
    #1 chk("R5 latch after bus", rd_pu, 8'h5A);
    chk_pads("R9 bus released", 8'h5A, 0, '0);

    // R7: pin path through two-flop synchronizer
    rd_latch_en = 0; rd_pin_en = 1;
    begin
      logic [W-1:0] h1, h2;
      h1 = pin_in; h2 = pin_in;
      tick(); tick();
      h1 = pin_in; h2 = pin_in;
      for (int v = 0; v < 256; v++) begin
        pin_in = W'(v * 37 + 11);
        tick();
        h2 = h1; h1 = pin_in;
        chk("R7 pin read delay", rd_pu, h2);
      end
      pin_in = 8'hC3;
      tick();
      chk("R7 one edge still old", rd_pu, h1);
      tick();
      chk("R7 two edges new", rd_pu, 8'hC3);
    end
    rd_latch_en = 1;
    #1 chk("R7 latch wins over pin", rd_pu, 8'h5A);
    rd_latch_en = 0; rd_pin_en = 0;
    #1 chk("R7 no strobe zero", rd_pu, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule